// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block holds a row of stages that can be filled all at once from a parallel data word and then emptied one bit at a time through a serial output. A level-sensitive load control, active low, copies the parallel word into every stage for as long as it is held low. While the control is high, each shift event moves every stage one place toward the last stage. The serial fill input supplies the new value of the first stage. The last stage drives the serial output, and a second output carries its complement.

Shift events come from two external inputs, a shift clock and a gating input, which play the same role. The block treats their logical OR as the effective clock, so a rising edge of either input while the other is low causes one shift. The block itself runs on a free-running system clock. It passes the shift clock, gating input, load control and serial fill through synchronizer chains, then detects a shift event as a 0-to-1 change of the synchronized OR.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0, so `tap_o` is 0 and `tap_n_o` is 1 after reset.
- R2: While `load_n_i` is low, every stage takes its parallel bit. `par_i[0]` goes to the first stage and `par_i[WIDTH-1]` to the last stage, so `tap_o` equals `par_i[WIDTH-1]`. This holds whatever the levels of the shift clock, gating input and serial fill.
- R3: While `load_n_i` is high, a rising `shift_clk_i` with `shift_gate_i` low moves stage i into stage i+1. After a load, the first shift therefore shows `par_i[WIDTH-2]` at `tap_o`.
- R4: On every shift, the first stage takes the level of `fill_i`. After WIDTH shifts, the fill bits come out at `tap_o` in the order they were entered.
- R5: A rising `shift_gate_i` while `shift_clk_i` is low causes exactly one shift.
- R6: A rising `shift_clk_i` while `shift_gate_i` is high causes no shift. Likewise, any change that does not raise the OR of the two inputs from 0 to 1 causes no shift, and the stages keep their values.
- R7: When a shift event and an asserted load fall in the same system cycle, the load wins and the shift is discarded. Toggling the clocks while the load is held low never disturbs the loaded word.
- R8: `tap_n_o` is always the complement of `tap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | External shift clock, asynchronous |
| shift_gate_i | input | 1 | Gating input, interchangeable with the shift clock, asynchronous |
| load_n_i | input | 1 | Load control: low loads the parallel word, high allows shifting |
| fill_i | input | 1 | Serial fill bit for the first stage |
| par_i | input | WIDTH | Parallel data; bit 0 to first stage, top bit to last stage |
| tap_o | output | 1 | Last stage value (serial output) |
| tap_n_o | output | 1 | Complement of the last stage value |

## Verification
The bench builds the block with WIDTH of 8 and two synchronizer stages. At this width, all 256 parallel words can be loaded and each one shifted fully out. Each shift alternates between the clock and the gating input, and the fill bits are derived from the loaded word, so every stage position and both event sources see both bit values. Short directed sequences then cover a clock edge masked by a high gating input, and a load applied while the clocks toggle, including a load that arrives in the same cycle as a clock edge.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // Operation chosen for the stage register in a given system cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } piso_op_e;

    // Index of each external input within the synchronized bundle
    localparam int unsigned SIG_CLK  = 0;
    localparam int unsigned SIG_GATE = 1;
    localparam int unsigned SIG_LOAD = 2;
    localparam int unsigned SIG_FILL = 3;
    localparam int unsigned SIG_COUNT = 4;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
        if (rst) begin
            state_d.chain = {STAGES{RESET_VAL}};
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign sync_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/piso_edge.sv
module piso_edge (
    input  logic clk,
    input  logic rst,
    input  logic clk_s_i,
    input  logic gate_s_i,
    output logic event_o
);

    typedef struct packed {
        logic prev_or;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic        or_now;

    always_comb begin
        or_now  = clk_s_i | gate_s_i;
        state_d = state_q;
        state_d.prev_or = or_now;
        if (rst) begin
            state_d.prev_or = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign event_o = or_now & ~state_q.prev_or;

    // R5 R6: an event marks a 0-to-1 change, so it never repeats in the next cycle
    single_evt_chk: assert property (@(posedge clk) disable iff (rst)
        event_o |=> !event_o);

    // R6: with the combined clock high in two consecutive cycles, no event follows
    masked_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_s_i || gate_s_i) |=> ((clk_s_i || gate_s_i) |-> !event_o));

endmodule

// File: rtl/piso_core.sv
module piso_core
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en_i,
    input  logic             shift_evt_i,
    input  logic             fill_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             last_o
);

    localparam int unsigned LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } core_state_t;

    core_state_t state_d, state_q;
    piso_op_e    op;

    // Load has priority over a coincident shift event
    always_comb begin
        if (load_en_i) begin
            op = OP_LOAD;
        end else if (shift_evt_i) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_LOAD:  state_d.stages = par_i;
            OP_SHIFT: state_d.stages = {state_q.stages[LAST-1:0], fill_i};
            default:  state_d.stages = state_q.stages;
        endcase
        if (rst) begin
            state_d.stages = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign last_o = state_q.stages[LAST];

    // R2 R7: an asserted load places the parallel word, even with a shift event present
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_en_i |=> (state_q.stages == $past(par_i)));

    // R3: a shift moves each stage one place toward the last stage
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_evt_i && !load_en_i) |=> (state_q.stages[LAST:1] == $past(state_q.stages[LAST-1:0])));

    // R4: a shift enters the fill bit into the first stage
    fill_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_evt_i && !load_en_i) |=> (state_q.stages[0] == $past(fill_i)));

    // R6: with neither load nor event, the stages keep their values
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_evt_i && !load_en_i) |=> $stable(state_q.stages));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_clk_i,
    input  logic             shift_gate_i,
    input  logic             load_n_i,
    input  logic             fill_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             tap_o,
    output logic             tap_n_o
);

    // Reset level of each synchronized input: load control idles high
    localparam logic [SIG_COUNT-1:0] SYNC_RESET = 4'b0100;

    logic [SIG_COUNT-1:0] raw_in;
    logic [SIG_COUNT-1:0] sync_in;
    logic                 shift_evt;
    logic                 last_bit;

    always_comb begin
        raw_in           = '0;
        raw_in[SIG_CLK]  = shift_clk_i;
        raw_in[SIG_GATE] = shift_gate_i;
        raw_in[SIG_LOAD] = load_n_i;
        raw_in[SIG_FILL] = fill_i;
    end

    for (genvar g = 0; g < int'(SIG_COUNT); g++) begin : g_sync
        piso_sync #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (SYNC_RESET[g])
        ) u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw_in[g]),
            .sync_o  (sync_in[g])
        );
    end

    piso_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .clk_s_i  (sync_in[SIG_CLK]),
        .gate_s_i (sync_in[SIG_GATE]),
        .event_o  (shift_evt)
    );

    piso_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .load_en_i   (~sync_in[SIG_LOAD]),
        .shift_evt_i (shift_evt),
        .fill_i      (sync_in[SIG_FILL]),
        .par_i       (par_i),
        .last_o      (last_bit)
    );

    assign tap_o   = last_bit;
    assign tap_n_o = ~last_bit;

endmodule

// File: tb/sim_piso_shift_reg.sv
module sim_piso_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shift_clk_i = 1'b0;
    logic         shift_gate_i = 1'b0;
    logic         load_n_i = 1'b1;
    logic         fill_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic         tap_o;
    logic         tap_n_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [W-1:0] model;

    always #4 clk = ~clk;

    piso_shift_reg #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst          (rst),
        .shift_clk_i  (shift_clk_i),
        .shift_gate_i (shift_gate_i),
        .load_n_i     (load_n_i),
        .fill_i       (fill_i),
        .par_i        (par_i),
        .tap_o        (tap_o),
        .tap_n_o      (tap_n_o)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
            summary();
        end
    end

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Output check plus the R8 complement check
    task automatic chk_tap(input string tag, input logic exp);
        chk(tag, tap_o, exp);
        chk("R8", tap_n_o, ~exp);
    endtask

    task automatic do_load(input logic [W-1:0] word);
        par_i = word;
        load_n_i = 1'b0;
        settle();
        chk_tap("R2", word[W-1]);
        load_n_i = 1'b1;
        settle();
        model = word;
    endtask

    // One shift by the clock input (gate low) or by the gate input (clock low)
    task automatic pulse(input logic by_gate, input logic f);
        fill_i = f;
        if (by_gate) shift_gate_i = 1'b1; else shift_clk_i = 1'b1;
        settle();
        if (by_gate) shift_gate_i = 1'b0; else shift_clk_i = 1'b0;
        settle();
        model = {model[W-2:0], f};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        // R1: reset state
        chk_tap("R1", 1'b0);

        // Sweep all parallel words
        for (int p = 0; p < (1 << W); p++) begin
            logic [W-1:0] fills;
            fills = W'(p) ^ 8'hA5;
            do_load(W'(p));
            for (int k = 0; k < W; k++) begin
                chk_tap(k == 0 ? "R2" : ((k % 2) == 0 ? "R5" : "R3"), model[W-1]);
                pulse(k[0], fills[k]);   // odd k: gate-driven shift (R5)
            end
            for (int k = 0; k < W; k++) begin
                chk_tap("R4", fills[k]);
                pulse(1'b0, 1'b0);
            end
        end

        // R6: clock edge masked by a high gate causes no shift
        do_load(8'h96);
        shift_clk_i = 1'b1; fill_i = 1'b1; settle();      // one shift
        model = {model[W-2:0], 1'b1};
        chk_tap("R3", model[W-1]);
        shift_gate_i = 1'b1; settle();                    // OR already high
        chk_tap("R6", model[W-1]);
        shift_clk_i = 1'b0; settle();
        chk_tap("R6", model[W-1]);
        shift_clk_i = 1'b1; settle();                     // rise while gate high
        chk_tap("R6", model[W-1]);
        shift_clk_i = 1'b0; settle();
        shift_gate_i = 1'b0; settle();
        chk_tap("R6", model[W-1]);
        for (int k = 0; k < W; k++) begin
            chk_tap("R6", model[W-1]);
            pulse(1'b0, 1'b0);
        end

        // R7: load held low while clocks and fill toggle
        par_i = 8'h3C;
        load_n_i = 1'b0;
        for (int t = 0; t < 6; t++) begin
            shift_clk_i = t[0];
            shift_gate_i = t[1];
            fill_i = ~fill_i;
            settle();
            chk_tap("R7", 1'b0);
        end
        par_i = 8'hC3;
        settle();
        chk_tap("R7", 1'b1);
        shift_clk_i = 1'b0; shift_gate_i = 1'b0; settle();
        // Load and clock edge in the same cycle
        par_i = 8'h5A;
        load_n_i = 1'b0;
        shift_clk_i = 1'b1;
        settle();
        load_n_i = 1'b1;                                  // released with clock high
        settle();
        shift_clk_i = 1'b0;
        settle();
        model = 8'h5A;
        for (int k = 0; k < W; k++) begin
            chk_tap("R7", model[W-1]);
            pulse(k[0], 1'b0);
        end

        summary();
    end

endmodule